// File: doc/BRIEF.md
# Serial Audio Receiver with Resynchronized Output Timing

This block receives a two-channel serial audio stream made of a data line, a bit clock and a word clock. It turns each channel word into a parallel sample. Completed left/right pairs then cross into the system-clock domain. There, a free-running timing counter decides when each pair is released as a one-cycle strobe. Because the counter runs only on the system clock, phase offsets and jitter on the incoming clocks do not reach the output strobes.

A speed-select input picks the frame period: 384 system clocks at normal speed, or 192 at double speed. That input is read only while reset is held. An active-low reset mutes both outputs. After release, the counter waits for the next rising word-clock edge and starts in step with it, and only then are the outputs unmuted.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data is captured on the rising bit-clock edge, MSB first, and treated as a 16-bit two's complement word. Word clock high marks the left channel and low marks the right channel. The sample appears unchanged on `smp_left`/`smp_right`.
- R2: The number of bit clocks per channel may be 16 to 32. Only the 16 bits just before each word-clock transition form the sample, and any earlier leading bits are discarded.
- R3: A pair is handed over only after its right word is complete. Every strobed pair holds the left and right words of one and the same frame, and pairs never appear out of order.
- R4: With speed select low at reset, `smp_stb` pulses exactly every 384 system clocks.
- R5: With speed select high at reset, `smp_stb` pulses exactly every 192 system clocks.
- R6: Speed select is sampled only while reset is held. Changing it during operation leaves the strobe interval unchanged.
- R7: While reset is held, `muted` is 1, `smp_stb` is 0 and both sample outputs are 0, even after earlier data has flowed.
- R8: After reset release, alignment happens on the next rising word-clock edge. `muted` falls 2 to 4 system clocks after that edge, and the first strobe comes P+2 to P+4 clocks after it, where P is the selected period.
- R9: `smp_stb` is high for exactly one system clock at a time.
- R10: Changing the bit-clock rate or its phase during operation does not change the strobe interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on clk |
| speed_dbl | input | 1 | 0: 384 clocks per frame, 1: 192 clocks per frame |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Word clock, high = left channel |
| sdata | input | 1 | Serial data, MSB first |
| smp_stb | output | 1 | One-cycle sample release strobe |
| smp_left | output | 16 | Left sample, two's complement |
| smp_right | output | 16 | Right sample, two's complement |
| muted | output | 1 | High while outputs are forced to zero |

## Verification
Two events can land in the same system-clock cycle: the arrival of a newly handed-over pair in the holding register, and the counter wrap that copies that register to the outputs. The bench provokes this coincidence by shifting the bit-clock phase. It also switches between 32 and 64 bit clocks per frame and between the two speeds, and each change moves the arrival point relative to the wrap. At every strobe, the bench requires that the pair matches a transmitted left/right pair of a single frame, at an index no earlier than the last one seen. A torn pair or a pair that goes backwards is therefore reported.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int SAR_WORD_W = 16;

  typedef struct packed {
    logic [SAR_WORD_W-1:0] left;
    logic [SAR_WORD_W-1:0] right;
  } sar_pair_t;
endpackage

// File: rtl/sar_bit_capture.sv
// Bit-clock domain: shifts serial data in and latches the word that ends
// at each word-clock transition. A toggle flags each completed pair.
module sar_bit_capture
  import sar_pkg::*;
(
  input  logic      bck,
  input  logic      lrck,
  input  logic      sdata,
  output sar_pair_t pair_o,
  output logic      tog_o
);
  localparam int W = SAR_WORD_W;

  logic [W-1:0] shreg;
  logic         lr_q;
  logic [W-1:0] left_q;
  logic [W-1:0] right_q;
  logic         tog_q;

  always_ff @(posedge bck) begin
    lr_q  <= lrck;
    shreg <= {shreg[W-2:0], sdata};
    if (lrck != lr_q) begin
      if (lr_q) begin
        left_q <= shreg;           // high half ended: left word
      end else begin
        right_q <= shreg;          // low half ended: pair complete
        tog_q   <= ~tog_q;
      end
    end
  end

  assign pair_o.left  = left_q;
  assign pair_o.right = right_q;
  assign tog_o        = tog_q;
endmodule

// File: rtl/sar_sync.sv
// Multi-stage synchronizer chain, one bit per lane.
module sar_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_timer.sv
// System-clock timing counter: aligns on a word-clock rise after reset,
// then releases the held pair on every wrap.
module sar_timer
  import sar_pkg::*;
#(
  parameter int NORM_DIV = 384,
  parameter int FAST_DIV = 192
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      speed_dbl,
  input  logic      lr_rise,
  input  logic      pair_new,
  input  sar_pair_t pair_in,
  output logic      stb_o,
  output sar_pair_t pair_o,
  output logic      mute_o
);
  localparam int MAXD = (NORM_DIV > FAST_DIV) ? NORM_DIV : FAST_DIV;
  localparam int CW   = $clog2(MAXD);
  localparam logic [CW-1:0] NORM_TOP = CW'(NORM_DIV - 1);
  localparam logic [CW-1:0] FAST_TOP = CW'(FAST_DIV - 1);

  logic [CW-1:0] period_q;
  logic [CW-1:0] cnt;
  logic          run;
  sar_pair_t     hold;

  always_ff @(posedge clk) begin
    if (pair_new) hold <= pair_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= speed_dbl ? FAST_TOP : NORM_TOP;
      cnt      <= '0;
      run      <= 1'b0;
      stb_o    <= 1'b0;
      pair_o   <= '0;
      mute_o   <= 1'b1;
    end else begin
      stb_o <= 1'b0;
      if (!run) begin
        if (lr_rise) begin
          run    <= 1'b1;
          cnt    <= '0;
          mute_o <= 1'b0;
        end
      end else if (cnt == period_q) begin
        cnt    <= '0;
        stb_o  <= 1'b1;
        pair_o <= hold;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_reset_mute_r7: assert property (@(posedge clk)
    rst |=> (mute_o && !stb_o));
  p_mute_zero_r7: assert property (@(posedge clk) disable iff (rst)
    mute_o |-> (pair_o == '0 && !stb_o));
  p_stb_width_r9: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= period_q);
  p_period_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(period_q));
  p_align_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(mute_o) |-> $past(lr_rise));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int NORM_DIV    = 384,
  parameter int FAST_DIV    = 192,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  speed_dbl,
  input  logic                  bck,
  input  logic                  lrck,
  input  logic                  sdata,
  output logic                  smp_stb,
  output logic [SAR_WORD_W-1:0] smp_left,
  output logic [SAR_WORD_W-1:0] smp_right,
  output logic                  muted
);
  logic      rst;
  sar_pair_t cap_pair;
  logic      cap_tog;
  logic [1:0] sync_out;
  logic      lr_d, tog_d;
  logic      lr_rise, pair_new;
  sar_pair_t out_pair;

  assign rst = ~rst_n;

  sar_bit_capture u_cap (
    .bck    (bck),
    .lrck   (lrck),
    .sdata  (sdata),
    .pair_o (cap_pair),
    .tog_o  (cap_tog)
  );

  sar_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({lrck, cap_tog}),
    .q   (sync_out)
  );

  always_ff @(posedge clk) begin
    lr_d  <= sync_out[1];
    tog_d <= sync_out[0];
  end

  assign lr_rise  = sync_out[1] & ~lr_d;
  assign pair_new = sync_out[0] ^ tog_d;

  sar_timer #(.NORM_DIV(NORM_DIV), .FAST_DIV(FAST_DIV)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .speed_dbl (speed_dbl),
    .lr_rise   (lr_rise),
    .pair_new  (pair_new),
    .pair_in   (cap_pair),
    .stb_o     (smp_stb),
    .pair_o    (out_pair),
    .mute_o    (muted)
  );

  assign smp_left  = out_pair.left;
  assign smp_right = out_pair.right;

  // R3: handed-over pairs arrive as isolated single-cycle events
  p_handoff_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    pair_new |=> !pair_new);
endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_dbl = 1'b0;
  logic bck = 1'b0;
  logic lrck = 1'b0;
  logic sdata = 1'b0;
  logic smp_stb, muted;
  logic [15:0] smp_left, smp_right;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .speed_dbl(speed_dbl), .bck(bck), .lrck(lrck),
    .sdata(sdata), .smp_stb(smp_stb), .smp_left(smp_left),
    .smp_right(smp_right), .muted(muted)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int gen_half = 30, gen_bits = 32, gen_shift = 0;
  logic [15:0] sent_l [0:1023];
  logic [15:0] sent_r [0:1023];
  int sent_cnt = 0;
  int last_idx = 0, n_stb = 0, exp_p = 384;
  int rise_cyc = 0, last_stb_cyc = 0;
  bit arm_rise = 0, first_stb = 0, first_mute = 0, prev_stb = 0, prev_mute = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int find_pair(input logic [15:0] l, input logic [15:0] r, input int from);
    for (int k = from; k < sent_cnt; k++)
      if (sent_l[k] == l && sent_r[k] == r) return k;
    return -1;
  endfunction

  // serial stream generator: left half (lrck high) then right half
  task automatic send_frame();
    logic [15:0] w [2];
    int bits, half;
    bits = gen_bits; half = gen_half;
    w[0] = 16'($urandom); w[1] = 16'($urandom);
    sent_l[sent_cnt] = w[0]; sent_r[sent_cnt] = w[1];
    sent_cnt++;
    if (gen_shift != 0) begin #(gen_shift); gen_shift = 0; end
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < bits; b++) begin
        int k;
        k = bits - 1 - b;
        bck = 1'b0;
        lrck = (ch == 0);
        sdata = (k < 16) ? w[ch][k] : 1'($urandom);
        #(half);
        bck = 1'b1;
        #(half);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd7301));
    #3;
    forever send_frame();
  end

  always @(posedge lrck) if (arm_rise) begin rise_cyc = cyc; arm_rise = 0; end

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_mute && !muted && first_mute) begin
        chk((cyc - rise_cyc) >= 2 && (cyc - rise_cyc) <= 4,
            "R8 mute release delay", cyc - rise_cyc, 3);
        first_mute = 0;
      end
      if (smp_stb) begin
        int idx;
        chk(!prev_stb, "R9 strobe width", 2, 1);
        if (first_stb) begin
          chk((cyc - rise_cyc) >= exp_p + 2 && (cyc - rise_cyc) <= exp_p + 4,
              "R8 first strobe delay", cyc - rise_cyc, exp_p + 3);
          first_stb = 0;
        end else begin
          chk((cyc - last_stb_cyc) == exp_p,
              (exp_p == 384) ? "R4 R10 strobe interval" : "R5 R10 strobe interval",
              cyc - last_stb_cyc, exp_p);
        end
        idx = find_pair(smp_left, smp_right, last_idx);
        n_chk++;
        if (idx < 0) begin
          n_fail++;
          $display("FAIL %s R3: actual L=%h R=%h expected a sent pair at index >= %0d",
                   (gen_bits > 16) ? "R2" : "R1", smp_left, smp_right, last_idx);
        end else last_idx = idx;
        last_stb_cyc = cyc;
        n_stb++;
      end
    end
    prev_stb = smp_stb;
    prev_mute = muted;
  end

  task automatic check_reset_state(input string tag);
    chk(muted == 1'b1, {tag, " muted"}, int'(muted), 1);
    chk(smp_stb == 1'b0, {tag, " strobe"}, int'(smp_stb), 0);
    chk(smp_left == 16'd0 && smp_right == 16'd0, {tag, " data"},
        int'({smp_left, smp_right}), 0);
  endtask

  task automatic release_reset(input int period);
    @(negedge lrck);
    @(negedge clk);
    exp_p = period;
    first_stb = 1; first_mute = 1; arm_rise = 1;
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20) @(negedge clk);
    check_reset_state("R7 initial");
    release_reset(384);
    wait (n_stb >= 25);
    // R6 speed change in run; R10 bit-clock rate and phase change
    @(negedge clk);
    speed_dbl = 1'b1;
    gen_half = 60; gen_bits = 16; gen_shift = 4;
    wait (n_stb >= 40);
    @(negedge clk);
    rst_n = 1'b0;
    gen_half = 15; gen_bits = 32;
    repeat (500) @(negedge clk);
    check_reset_state("R7 after data");
    release_reset(192);
    wait (n_stb >= 70);
    @(negedge clk);
    speed_dbl = 1'b0;          // R6: ignored until next reset
    wait (n_stb >= 85);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end
endmodule